// File: doc/BRIEF.md
# Alternating-Reload One-Shot Phase Timer

This block is a one-shot down-counter that drives a single phase of a three-phase output stage. A start trigger arrives while the timer is idle. The timer then copies a reload value from one of two 16-bit preset registers and counts ticks of a count-source enable. When the last tick has been counted, the timer goes idle, inverts its phase output and issues a one-clock stop pulse. A later dead-time stage uses that pulse to activate the phase.

The block has two reload modes. In single mode, every trigger loads the primary preset. In alternating mode, the trigger loads come from the secondary preset and the primary preset in turn, with the secondary preset first after reset. A selected preset of zero starts nothing. Presets are written as whole 16-bit words. A write is discarded when it arrives in the same cycle as the underflow of the external period timer.

Top module: `phase_oneshot_timer`

## Requirements
- R1: After an accepted trigger loads value n (n > 0), the timer stays busy until the nth cycle with `tick_en` high that follows the trigger cycle. A tick in the trigger cycle itself is not counted. Clock cycles with `tick_en` low are not counted.
- R2: `phase_out` (0 = positive, 1 = negative) inverts at every expiry and changes at no other time.
- R3: At expiry, `stop_pulse` is high for exactly one clock. It rises at the same edge where `busy` falls.
- R4: With `alt_mode` = 0 (single mode), every accepted trigger loads the primary preset.
- R5: With `alt_mode` = 1, the first accepted trigger after reset loads the secondary preset. The next one loads the primary preset, and the selection keeps alternating on each accepted trigger. This includes triggers whose selected preset is zero.
- R6: If the selected preset is zero, the trigger does not start the timer. `busy` stays 0, no stop pulse is produced and `phase_out` is unchanged.
- R7: A preset write issued while `period_uf` is high is discarded. The preset keeps its previous value.
- R8: Reset sets the timer to this state: `phase_out` = 0, `busy` = 0, `stop_pulse` = 0, both presets = 0, and the alternation pointer pointing at the secondary preset.
- R9: A trigger that arrives while `busy` is high is ignored. It neither reloads the counter nor advances the alternation pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-source tick, one count per high cycle |
| start_trg | input | 1 | Start trigger |
| pri_we | input | 1 | Primary preset write strobe |
| pri_wdata | input | 16 | Primary preset write value |
| sec_we | input | 1 | Secondary preset write strobe |
| sec_wdata | input | 16 | Secondary preset write value |
| alt_mode | input | 1 | 0 = single reload, 1 = alternating reload |
| period_uf | input | 1 | External period-timer underflow; blocks preset writes |
| phase_out | output | 1 | Phase state, 0 positive, 1 negative |
| stop_pulse | output | 1 | One-clock pulse at expiry |
| busy | output | 1 | Timer counting |

## Verification
A table of mode and preset pairs drives three shots per row. Each shot measures the shot length in counted ticks while the tick enable has gaps and is also high during the trigger cycle. A mismatch shows whether a tick was counted wrongly, whether the wrong preset was chosen, or whether the alternation started on the wrong side. Rows with a zero preset in alternating mode show whether a refused trigger still advances the pointer. Directed cases cover the reset state, a write that collides with the underflow, and a retrigger during a shot. In the retrigger case, the following shot's length shows whether the ignored trigger moved the pointer.

// File: rtl/phase_timer_pkg.sv
package phase_timer_pkg;
  typedef enum logic {
    RELOAD_SINGLE = 1'b0,
    RELOAD_ALT    = 1'b1
  } reload_mode_e;

  localparam logic PHASE_POS = 1'b0;
  localparam logic PHASE_NEG = 1'b1;
endpackage

// File: rtl/preset_bank.sv
module preset_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         period_uf,
  input  logic         pri_we,
  input  logic [W-1:0] pri_wdata,
  input  logic         sec_we,
  input  logic [W-1:0] sec_wdata,
  output logic [W-1:0] pri_q,
  output logic [W-1:0] sec_q
);
  logic pri_wr_ok;
  logic sec_wr_ok;

  assign pri_wr_ok = pri_we && !period_uf;
  assign sec_wr_ok = sec_we && !period_uf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      if (pri_wr_ok) pri_q <= pri_wdata;
      if (sec_wr_ok) sec_q <= sec_wdata;
    end
  end

  // R7
  uf_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_uf |=> ($stable(pri_q) && $stable(sec_q)));
endmodule

// File: rtl/reload_select.sv
module reload_select
  import phase_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_req,
  input  reload_mode_e mode,
  input  logic [W-1:0] pri_val,
  input  logic [W-1:0] sec_val,
  output logic [W-1:0] sel_val
);
  logic use_pri_q;

  function automatic logic [W-1:0] pick_preset(
    input reload_mode_e m,
    input logic         ptr_pri,
    input logic [W-1:0] p,
    input logic [W-1:0] s
  );
    if (m == RELOAD_SINGLE) return p;
    return ptr_pri ? p : s;
  endfunction

  assign sel_val = pick_preset(mode, use_pri_q, pri_val, sec_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) use_pri_q <= 1'b0;
    else if (load_req && mode == RELOAD_ALT) use_pri_q <= !use_pri_q;
  end

  // R5
  alt_ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && mode == RELOAD_ALT) |=> (use_pri_q != $past(use_pri_q)));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> $stable(use_pri_q));
endmodule

// File: rtl/oneshot_counter.sv
module oneshot_counter
  import phase_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         start_trg,
  input  logic [W-1:0] load_val,
  output logic         load_req,
  output logic         phase_q,
  output logic         stop_q,
  output logic         busy_q
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         expire;
  logic         zero_load;

  function automatic logic [W-1:0] count_down(input logic [W-1:0] c);
    return c - ONE;
  endfunction

  assign load_req  = start_trg && !busy_q;
  assign zero_load = load_req && (load_val == '0);
  assign expire    = busy_q && tick_en && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      phase_q <= PHASE_POS;
      stop_q  <= 1'b0;
    end else begin
      stop_q <= 1'b0;
      if (load_req) begin
        cnt_q  <= load_val;
        busy_q <= !zero_load;
      end else if (expire) begin
        busy_q  <= 1'b0;
        phase_q <= !phase_q;
        stop_q  <= 1'b1;
        cnt_q   <= '0;
      end else if (busy_q && tick_en) begin
        cnt_q <= count_down(cnt_q);
      end
    end
  end

  // R3
  stop_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !stop_q);

  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !busy_q);

  // R2
  phase_only_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> stop_q);

  // R6
  zero_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_load |=> (!busy_q && !stop_q));

  // R1
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_en) |=> ($stable(cnt_q) && busy_q));
endmodule

// File: rtl/phase_oneshot_timer.sv
module phase_oneshot_timer
  import phase_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         start_trg,
  input  logic         pri_we,
  input  logic [W-1:0] pri_wdata,
  input  logic         sec_we,
  input  logic [W-1:0] sec_wdata,
  input  logic         alt_mode,
  input  logic         period_uf,
  output logic         phase_out,
  output logic         stop_pulse,
  output logic         busy
);
  logic [W-1:0] pri_val;
  logic [W-1:0] sec_val;
  logic [W-1:0] sel_val;
  logic         load_req;
  reload_mode_e mode;

  assign mode = alt_mode ? RELOAD_ALT : RELOAD_SINGLE;

  preset_bank #(.W(W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_uf (period_uf),
    .pri_we    (pri_we),
    .pri_wdata (pri_wdata),
    .sec_we    (sec_we),
    .sec_wdata (sec_wdata),
    .pri_q     (pri_val),
    .sec_q     (sec_val)
  );

  reload_select #(.W(W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_req (load_req),
    .mode     (mode),
    .pri_val  (pri_val),
    .sec_val  (sec_val),
    .sel_val  (sel_val)
  );

  oneshot_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .start_trg (start_trg),
    .load_val  (sel_val),
    .load_req  (load_req),
    .phase_q   (phase_out),
    .stop_q    (stop_pulse),
    .busy_q    (busy)
  );

  // R9
  busy_ignores_trg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_trg) |-> !load_req);
endmodule

// File: tb/sim_phase_oneshot_timer.sv
module sim_phase_oneshot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        start_trg = 1'b0;
  logic        pri_we = 1'b0;
  logic [15:0] pri_wdata = '0;
  logic        sec_we = 1'b0;
  logic [15:0] sec_wdata = '0;
  logic        alt_mode = 1'b0;
  logic        period_uf = 1'b0;
  logic        phase_out;
  logic        stop_pulse;
  logic        busy;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  logic exp_phase = 1'b0;

  // {alt, primary, secondary}
  localparam logic [32:0] VECS [0:5] = '{
    {1'b0, 16'd5, 16'd9},
    {1'b1, 16'd4, 16'd7},
    {1'b1, 16'd1, 16'd3},
    {1'b0, 16'd1, 16'd2},
    {1'b1, 16'd6, 16'd0},
    {1'b1, 16'd0, 16'd2}
  };

  always #10 clk = !clk;

  phase_oneshot_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start_trg(start_trg),
    .pri_we(pri_we), .pri_wdata(pri_wdata), .sec_we(sec_we), .sec_wdata(sec_wdata),
    .alt_mode(alt_mode), .period_uf(period_uf),
    .phase_out(phase_out), .stop_pulse(stop_pulse), .busy(busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog: act %0d cycles exp fewer", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_trg = 1'b0; tick_en = 1'b0; pri_we = 1'b0; sec_we = 1'b0; period_uf = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_phase = 1'b0;
  endtask

  task automatic wr_pri(input int v, input bit uf);
    @(negedge clk);
    pri_we = 1'b1; pri_wdata = 16'(v); period_uf = uf;
    @(negedge clk);
    pri_we = 1'b0; period_uf = 1'b0;
  endtask

  task automatic wr_sec(input int v);
    @(negedge clk);
    sec_we = 1'b1; sec_wdata = 16'(v);
    @(negedge clk);
    sec_we = 1'b0;
  endtask

  // Trigger with a tick in the trigger cycle, then gapped ticks until stop.
  task automatic run_shot(input int n, input string req);
    int got;
    bit seen;
    got = 0;
    seen = 1'b0;
    @(negedge clk);
    start_trg = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    start_trg = 1'b0;
    chk(busy == 1'b1, "R1", "busy after trigger", int'(busy), 1);
    for (int c = 0; c < 2000 && !seen; c++) begin
      tick_en = (c % 3 != 2);
      @(negedge clk);
      if (tick_en) got++;
      if (stop_pulse) seen = 1'b1;
    end
    tick_en = 1'b0;
    exp_phase = !exp_phase;
    chk(got == n, req, "ticks to expiry", got, n);
    chk(busy == 1'b0, "R3", "busy low with stop pulse", int'(busy), 0);
    chk(phase_out == exp_phase, "R2", "phase after expiry", int'(phase_out), int'(exp_phase));
    @(negedge clk);
    chk(stop_pulse == 1'b0, "R3", "stop pulse width", int'(stop_pulse), 0);
  endtask

  task automatic zero_shot(input string req);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    start_trg = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    start_trg = 1'b0;
    for (int c = 0; c < 4; c++) begin
      if (busy || stop_pulse) seen = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
    chk(!seen, req, "zero preset started timer", int'(seen), 0);
    chk(phase_out == exp_phase, "R6", "phase after zero trigger", int'(phase_out), int'(exp_phase));
  endtask

  initial begin
    do_reset();
    // R8 reset state
    chk(phase_out == 1'b0, "R8", "phase after reset", int'(phase_out), 0);
    chk(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
    chk(stop_pulse == 1'b0, "R8", "stop after reset", int'(stop_pulse), 0);
    alt_mode = 1'b1;
    zero_shot("R8");

    // table of mode/preset rows, three shots each
    for (int v = 0; v < 6; v++) begin
      bit ptr_pri;
      int val;
      do_reset();
      alt_mode = VECS[v][32];
      wr_pri(int'(VECS[v][31:16]), 1'b0);
      wr_sec(int'(VECS[v][15:0]));
      ptr_pri = 1'b0;
      for (int s = 0; s < 3; s++) begin
        if (alt_mode) begin
          val = ptr_pri ? int'(VECS[v][31:16]) : int'(VECS[v][15:0]);
          ptr_pri = !ptr_pri;
        end else begin
          val = int'(VECS[v][31:16]);
        end
        if (val == 0) zero_shot(alt_mode ? "R5/R6" : "R4/R6");
        else run_shot(val, alt_mode ? "R1/R5" : "R1/R4");
      end
    end

    // R7 write colliding with period underflow is dropped
    do_reset();
    alt_mode = 1'b0;
    wr_pri(4, 1'b0);
    wr_pri(11, 1'b1);
    run_shot(4, "R7");
    wr_pri(11, 1'b0);
    run_shot(11, "R7");

    // R9 retrigger while busy: no reload, pointer unchanged
    do_reset();
    alt_mode = 1'b1;
    wr_pri(3, 1'b0);
    wr_sec(6);
    begin
      int got;
      bit seen;
      got = 0;
      seen = 1'b0;
      @(negedge clk);
      start_trg = 1'b1; tick_en = 1'b1;
      @(negedge clk);
      start_trg = 1'b0;
      for (int c = 0; c < 100 && !seen; c++) begin
        tick_en = 1'b1;
        start_trg = (c == 2);
        @(negedge clk);
        got++;
        if (stop_pulse) seen = 1'b1;
      end
      start_trg = 1'b0; tick_en = 1'b0;
      exp_phase = !exp_phase;
      chk(got == 6, "R9", "ticks with retrigger", got, 6);
      @(negedge clk);
    end
    run_shot(3, "R9");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule